// File: doc/BRIEF.md
# Periodic Backup-Battery Health Sampler

This block decides when a backup battery is put under a test load and when its voltage is judged. It counts microsecond ticks from the moment the system reset is released. Once every measurement period it raises a load-enable output for a short on-time. The external resistive load and the comparator work only while that output is high, so the battery is loaded for a few microseconds out of every period.

The comparator result is read once per window, on the last tick of the window, so that the divider and the comparator have settled. A failing reading pulls the battery-OK flag low. A later passing reading sets it high again. Between readings the flag holds its value, and it is high whenever reset is asserted. The period and the on-time are parameters in ticks. The defaults give 200 ms and 25 µs with a 1 µs tick.

Top module: `battery_health_sampler`

## Requirements
- R1: After `rst_released` rises, the first window starts on the PERIOD_TICKS-th tick. Each later window starts exactly PERIOD_TICKS ticks after the one before it.
- R2: While `rst_released` is low, `measure_en` is 0 and `battok` is 1 one clock later, whatever `tick_us` does. The tick count restarts from zero on the next release.
- R3: `measure_en` rises on the clock edge that takes the starting tick. It stays high for exactly ON_TICKS further ticks and falls on the edge that takes the last of them.
- R4: `bat_above_th` is read only on the last tick of a window. Its value on every other tick and between ticks has no effect on `battok`.
- R5: If the reading is 0 (battery below threshold), `battok` goes to 0 on the same edge on which `measure_en` falls.
- R6: If the reading is 1, `battok` is 1 after that edge, so a passing reading restores a flag that an earlier reading cleared.
- R7: On a clock without `tick_us`, neither `measure_en` nor `battok` changes while reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| tick_us | input | 1 | One-clock time-base strobe, one per microsecond |
| rst_released | input | 1 | High once the system reset is released. Low holds the block in its reset state |
| bat_above_th | input | 1 | Comparator result: 1 means the battery is above the threshold |
| measure_en | output | 1 | Enables the battery test load during a measurement window |
| battok | output | 1 | Battery status flag: 1 means OK |

## Verification
Every result is registered once. `measure_en` and `battok` therefore change on the clock edge that takes the tick concerned and are stable from the following falling edge. The bench drives each tick in a single clock between falling edges and checks both outputs at the next falling edge. It then leaves at least one tick-free clock, during which the comparator input is inverted and both outputs are checked again for no change. The bench keeps its own tick count n since release. It expects the window to be open when n is at least the period and n mod the period is below the on-time. It expects a new flag value exactly when n mod the period equals the on-time.

// File: rtl/bhs_pkg.sv
package bhs_pkg;

  // Width of a counter that must hold values 0 .. n-1 (at least one bit).
  function automatic int cnt_w(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bhs_period_timer.sv
module bhs_period_timer #(
  parameter int LIMIT = 200000
) (
  input  logic clk,
  input  logic run,
  input  logic tick,
  output logic start_evt
);
  localparam int W = bhs_pkg::cnt_w(LIMIT);

  logic [W-1:0] cnt_q;

  function automatic logic at_last(input logic [W-1:0] c);
    return c == W'(LIMIT - 1);
  endfunction

  function automatic logic [W-1:0] advance(input logic [W-1:0] c);
    return at_last(c) ? '0 : c + W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= advance(cnt_q);
    end
  end

  assign start_evt = run && tick && at_last(cnt_q);
endmodule

// File: rtl/bhs_window_timer.sv
module bhs_window_timer #(
  parameter int ON = 25
) (
  input  logic clk,
  input  logic run,
  input  logic tick,
  input  logic start_evt,
  output logic win_en,
  output logic last_evt
);
  localparam int W = bhs_pkg::cnt_w(ON);

  logic [W-1:0] on_q;

  function automatic logic final_tick(input logic [W-1:0] c);
    return c == W'(ON - 1);
  endfunction

  assign last_evt = win_en && tick && final_tick(on_q);

  always_ff @(posedge clk) begin
    if (!run) begin
      win_en <= 1'b0;
      on_q   <= '0;
    end else if (start_evt) begin
      win_en <= 1'b1;
      on_q   <= '0;
    end else if (win_en && tick) begin
      if (final_tick(on_q)) begin
        win_en <= 1'b0;
        on_q   <= '0;
      end else begin
        on_q <= on_q + W'(1);
      end
    end
  end
endmodule

// File: rtl/bhs_status_flag.sv
module bhs_status_flag (
  input  logic clk,
  input  logic run,
  input  logic sample_evt,
  input  logic reading,
  output logic ok
);
  always_ff @(posedge clk) begin
    if (!run) begin
      ok <= 1'b1;
    end else if (sample_evt) begin
      ok <= reading;
    end
  end
endmodule

// File: rtl/battery_health_sampler.sv
module battery_health_sampler #(
  parameter int PERIOD_TICKS = 200000,
  parameter int ON_TICKS     = 25
) (
  input  logic clk,
  input  logic tick_us,
  input  logic rst_released,
  input  logic bat_above_th,
  output logic measure_en,
  output logic battok
);
  // ON_TICKS must be smaller than PERIOD_TICKS so that each window closes before the next one starts.
  logic start_evt;
  logic sample_evt;

  bhs_period_timer #(.LIMIT(PERIOD_TICKS)) u_period (
    .clk       (clk),
    .run       (rst_released),
    .tick      (tick_us),
    .start_evt (start_evt)
  );

  bhs_window_timer #(.ON(ON_TICKS)) u_window (
    .clk       (clk),
    .run       (rst_released),
    .tick      (tick_us),
    .start_evt (start_evt),
    .win_en    (measure_en),
    .last_evt  (sample_evt)
  );

  bhs_status_flag u_flag (
    .clk        (clk),
    .run        (rst_released),
    .sample_evt (sample_evt),
    .reading    (bat_above_th),
    .ok         (battok)
  );
endmodule

// File: rtl/bhs_checker.sv
module bhs_checker #(
  parameter int PERIOD_TICKS = 200000,
  parameter int ON_TICKS     = 25
) (
  input logic clk,
  input logic tick_us,
  input logic rst_released,
  input logic bat_above_th,
  input logic measure_en,
  input logic battok,
  input logic start_evt,
  input logic sample_evt
);
  int unsigned since_start;
  int unsigned win_ticks;

  always_ff @(posedge clk) begin
    if (!rst_released || start_evt) begin
      since_start <= 0;
    end else if (tick_us) begin
      since_start <= since_start + 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_released || start_evt) begin
      win_ticks <= 0;
    end else if (measure_en && tick_us) begin
      win_ticks <= win_ticks + 1;
    end
  end

  a_r1_period: assert property (@(posedge clk) disable iff (!rst_released)
    start_evt |-> (since_start == PERIOD_TICKS - 1));

  a_r2_reset_quiet: assert property (@(posedge clk)
    !rst_released |=> (!measure_en && battok));

  a_r3_rise_on_start: assert property (@(posedge clk) disable iff (!rst_released)
    $rose(measure_en) |-> $past(start_evt));

  a_r3_window_length: assert property (@(posedge clk) disable iff (!rst_released)
    $fell(measure_en) |-> (win_ticks == ON_TICKS));

  a_r4_sample_in_window: assert property (@(posedge clk) disable iff (!rst_released)
    sample_evt |-> (measure_en && tick_us));

  a_r4_flag_moves_on_sample: assert property (@(posedge clk) disable iff (!rst_released)
    (battok != $past(battok)) |-> $past(sample_evt));

  a_r5_flag_takes_reading: assert property (@(posedge clk) disable iff (!rst_released)
    sample_evt |=> (battok == $past(bat_above_th)));

  a_r7_no_tick_no_change: assert property (@(posedge clk) disable iff (!rst_released)
    !tick_us |=> ($stable(measure_en) && $stable(battok)));
endmodule

bind battery_health_sampler bhs_checker #(
  .PERIOD_TICKS (PERIOD_TICKS),
  .ON_TICKS     (ON_TICKS)
) u_chk (
  .clk          (clk),
  .tick_us      (tick_us),
  .rst_released (rst_released),
  .bat_above_th (bat_above_th),
  .measure_en   (measure_en),
  .battok       (battok),
  .start_evt    (start_evt),
  .sample_evt   (sample_evt)
);

// File: tb/battery_health_sampler_tb.sv
module battery_health_sampler_tb;
  localparam int P  = 10;
  localparam int ON = 3;

  logic clk = 1'b0;
  logic tick_us = 1'b0;
  logic rst_released = 1'b0;
  logic bat_above_th = 1'b1;
  logic measure_en;
  logic battok;

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  logic exp_ok = 1'b1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  battery_health_sampler #(.PERIOD_TICKS(P), .ON_TICKS(ON)) u_dut (
    .clk          (clk),
    .tick_us      (tick_us),
    .rst_released (rst_released),
    .bat_above_th (bat_above_th),
    .measure_en   (measure_en),
    .battok       (battok)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (tick %0d)", tag, act, exp, n);
    end
  endtask

  // Comparator value presented on tick number k.
  function automatic logic pat(input int mode, input int k);
    case (mode)
      0: return 1'b1;
      1: return 1'b0;
      2: return (k % P == ON) ? 1'b0 : 1'b1;
      3: return (k % P == ON) ? 1'b1 : 1'b0;
      4: return ((k / P) % 2) == 1;
      default: return ((((k * 5) + 3) >> 2) & 1) == 1;
    endcase
  endfunction

  task automatic do_tick(input int mode);
    logic c;
    logic exp_en;
    c = pat(mode, n + 1);
    @(negedge clk);
    tick_us = 1'b1;
    bat_above_th = c;
    @(negedge clk);
    tick_us = 1'b0;
    n++;
    if (n >= P && (n % P) == ON) exp_ok = c;
    exp_en = (n >= P) && ((n % P) < ON);
    chk("R1 R3 measure_en", measure_en, exp_en);
    if (n >= P && (n % P) == ON) begin
      if (c) chk("R6 battok after passing reading", battok, exp_ok);
      else   chk("R5 battok after failing reading", battok, exp_ok);
    end else begin
      chk("R4 battok off the sample tick", battok, exp_ok);
    end
    bat_above_th = ~c;
    @(negedge clk);
    chk("R7 measure_en without tick", measure_en, exp_en);
    chk("R7 battok without tick", battok, exp_ok);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_released = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      tick_us = (k % 2) == 0;
      bat_above_th = 1'b0;
      chk("R2 measure_en in reset", measure_en, 1'b0);
      chk("R2 battok in reset", battok, 1'b1);
    end
    @(negedge clk);
    tick_us = 1'b0;
    rst_released = 1'b1;
    n = 0;
    exp_ok = 1'b1;
  endtask

  initial begin
    int modes [6] = '{0, 1, 2, 3, 4, 5};
    int lens  [6] = '{45, 32, 61, 50, 23, 57};
    repeat (3) @(negedge clk);
    for (int ph = 0; ph < 6; ph++) begin
      do_reset();
      for (int t = 0; t < lens[ph]; t++) do_tick(modes[ph]);
    end
    // Failing then passing readings on consecutive windows (R5 then R6).
    do_reset();
    for (int t = 0; t < 4 * P; t++) do_tick(4);
    do_reset();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule